// File: doc/BRIEF.md
# Trap Entry CSR Update Unit

This unit performs the state update that a hart makes when it takes a trap. A one-cycle trap event arrives with a cause code, a synchronous/asynchronous marker and the context of the fault. One clock later the unit issues a single write pulse to either the supervisor trap register set or the machine trap register set. With that pulse it provides the saved PC, the trap value, the trap-instruction value, the guest-virtual-address flag, the handler PC and the new privilege level.

The unit also holds a small fault record that the memory side loads when a fault is detected. The record keeps three bits: whether two-stage translation was active, whether the fault was a guest-stage fault taken while walking the guest's own page table (the indirect case), and whether the access is reported as a load. Trap selection reads the record. Once the trap has been entered, the two-stage and indirect bits are cleared. The trap-instruction value depends on the fault class. An indirect fault gets a fixed pseudoinstruction. Any other load/store fault gets the transformed instruction supplied from outside. Fetch faults and interrupts get zero.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the write enables are low, all value outputs are zero, `new_priv` is 3 (machine) and the record flags are clear.
- R2: A trap is delegated to supervisor when bit `trap_cause` of `ideleg` is set for an asynchronous trap, or bit `trap_cause` of `edeleg` is set for a synchronous one. The other mask is ignored.
- R3: For synchronous causes 4, 5, 6, 7, 13, 15, 21 and 23 (load/store class), `tval` equals `fault_addr` and `gva` equals the recorded two-stage flag.
- R4: For a load/store-class trap while the recorded indirect flag is set, `tinst` is 0x2000 when `is_rv32` is 1 and 0x3000 when it is 0.
- R5: For a load/store-class trap with the indirect flag clear, `tinst` is `xform_insn` zero-extended.
- R6: For synchronous causes 0, 1, 12 and 20 (fetch class), `tval` equals `fault_addr`, `gva` equals the two-stage flag and `tinst` is zero.
- R7: For an asynchronous trap, `tval`, `tinst` and `gva` are zero.
- R8: For any other synchronous cause, `tval`, `tinst` and `gva` are zero.
- R9: Each trap event causes exactly one pulse on `s_we` (with `new_priv` = 1) or `m_we` (with `new_priv` = 3), one cycle later, with `epc` equal to `cur_pc`. No pulse occurs without an event.
- R10: `new_pc` is the selected vector base with bits [1:0] cleared. If the trap is asynchronous and base bits [1:0] equal 01, 4 times the cause is added.
- R11: A record of kind 1 (guest-stage fault during the guest page walk) sets the indirect flag and forces the load flag regardless of `rec_store`.
- R12: A record of kind 2 (bus error) or kind 3 (misaligned) clears the indirect flag. Kinds 0, 2 and 3 load the two-stage flag from `rec_two_stage` and the load flag from `!rec_store`.
- R13: A trap event clears the two-stage and indirect flags. A record arriving in the same cycle as a trap is kept, and the trap uses the flags held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap event strobe |
| trap_async | input | 1 | Event is an interrupt |
| trap_cause | input | CAUSE_W | Cause code |
| ideleg | input | XLEN | Interrupt delegation mask |
| edeleg | input | XLEN | Exception delegation mask |
| fault_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| xform_insn | input | 32 | Transformed faulting instruction |
| is_rv32 | input | 1 | Current XLEN is 32 |
| svec | input | XLEN | Supervisor vector base and mode |
| mvec | input | XLEN | Machine vector base and mode |
| rec_valid | input | 1 | Fault record load strobe |
| rec_kind | input | 2 | 0 translation, 1 walk guest-stage, 2 bus error, 3 misaligned |
| rec_two_stage | input | 1 | Two-stage translation active for the recorded fault |
| rec_store | input | 1 | Recorded access is a store |
| s_we | output | 1 | Supervisor trap register write |
| m_we | output | 1 | Machine trap register write |
| epc | output | XLEN | Saved PC value |
| tval | output | XLEN | Trap value |
| tinst | output | XLEN | Trap-instruction value |
| gva | output | 1 | Guest-virtual-address flag |
| new_pc | output | XLEN | Handler PC |
| new_priv | output | 2 | New privilege level |
| flag_two_stage | output | 1 | Recorded two-stage flag |
| flag_indirect | output | 1 | Recorded indirect flag |
| flag_load | output | 1 | Recorded access is a load |

## Verification
Loading the fault record and clearing it on trap entry can happen in the same cycle. The bench provokes this by asserting `rec_valid` and `trap_valid` on the same clock while the held flags differ from the incoming record. It then judges two things: the trap's `gva` and `tinst` must reflect the older flags, and the flags read afterwards must equal the new record rather than zero. Back-to-back trap events are also driven, to check that each one produces its own write pulse, in order.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    REC_XLATE   = 2'd0,
    REC_WALK_GS = 2'd1,
    REC_BUS_ERR = 2'd2,
    REC_MISALGN = 2'd3
  } rec_kind_e;

  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [31:0] PSEUDO_WALK_32 = 32'h0000_2000;
  localparam logic [31:0] PSEUDO_WALK_64 = 32'h0000_3000;

  function automatic logic is_fetch_cause(input logic [31:0] c);
    return (c == 32'd0) || (c == 32'd1) || (c == 32'd12) || (c == 32'd20);
  endfunction

  function automatic logic is_ldst_cause(input logic [31:0] c);
    return (c == 32'd4) || (c == 32'd5) || (c == 32'd6) || (c == 32'd7) ||
           (c == 32'd13) || (c == 32'd15) || (c == 32'd21) || (c == 32'd23);
  endfunction

endpackage

// File: rtl/trap_fault_rec.sv
module trap_fault_rec
  import trap_entry_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rec_valid,
  input  rec_kind_e rec_kind,
  input  logic      rec_two_stage,
  input  logic      rec_store,
  input  logic      trap_fire,
  output logic      two_stage_q,
  output logic      indirect_q,
  output logic      load_q
);

  logic walk_gs;
  assign walk_gs = (rec_kind == REC_WALK_GS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      two_stage_q <= 1'b0;
      indirect_q  <= 1'b0;
      load_q      <= 1'b0;
    end else if (rec_valid) begin
      two_stage_q <= rec_two_stage;
      indirect_q  <= walk_gs;
      load_q      <= walk_gs | ~rec_store;
    end else if (trap_fire) begin
      two_stage_q <= 1'b0;
      indirect_q  <= 1'b0;
    end
  end

  assert_walk_sets_indirect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && (rec_kind == REC_WALK_GS) |=> indirect_q && load_q);

  assert_buserr_misalign_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && ((rec_kind == REC_BUS_ERR) || (rec_kind == REC_MISALGN)) |=> !indirect_q);

  assert_trap_clears_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire && !rec_valid |=> !two_stage_q && !indirect_q);

endmodule

// File: rtl/trap_classify.sv
module trap_classify
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 6
) (
  input  logic               async_ev,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    fault_addr,
  input  logic               two_stage,
  input  logic               indirect,
  input  logic               is_rv32,
  input  logic [31:0]        xform_insn,
  output logic               cls_ldst,
  output logic               cls_fetch,
  output logic [XLEN-1:0]    tval,
  output logic [XLEN-1:0]    tinst,
  output logic               gva
);

  logic [31:0] cidx;
  assign cidx = 32'(cause);

  function automatic logic [XLEN-1:0] pick_tinst(input logic ind, input logic rv32,
                                                 input logic [31:0] xf);
    if (ind) return XLEN'(rv32 ? PSEUDO_WALK_32 : PSEUDO_WALK_64);
    return XLEN'(xf);
  endfunction

  assign cls_ldst  = !async_ev && is_ldst_cause(cidx);
  assign cls_fetch = !async_ev && is_fetch_cause(cidx);

  always_comb begin
    tval  = '0;
    tinst = '0;
    gva   = 1'b0;
    if (cls_ldst) begin
      tval  = fault_addr;
      gva   = two_stage;
      tinst = pick_tinst(indirect, is_rv32, xform_insn);
    end else if (cls_fetch) begin
      tval  = fault_addr;
      gva   = two_stage;
    end
  end

endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 6
) (
  input  logic               async_ev,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    ideleg,
  input  logic [XLEN-1:0]    edeleg,
  input  logic [XLEN-1:0]    svec,
  input  logic [XLEN-1:0]    mvec,
  output logic               to_s,
  output logic [XLEN-1:0]    target_pc
);

  localparam int IDX_N = 1 << CAUSE_W;

  logic [IDX_N-1:0] imask, emask;
  logic [XLEN-1:0]  base;

  assign imask = IDX_N'(ideleg);
  assign emask = IDX_N'(edeleg);

  function automatic logic [XLEN-1:0] vec_target(input logic [XLEN-1:0] b,
                                                 input logic a,
                                                 input logic [CAUSE_W-1:0] c);
    logic [XLEN-1:0] aligned;
    aligned = {b[XLEN-1:2], 2'b00};
    if (a && (b[1:0] == 2'b01)) return aligned + XLEN'({c, 2'b00});
    return aligned;
  endfunction

  assign to_s      = async_ev ? imask[cause] : emask[cause];
  assign base      = to_s ? svec : mvec;
  assign target_pc = vec_target(base, async_ev, cause);

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_valid,
  input  logic               trap_async,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    ideleg,
  input  logic [XLEN-1:0]    edeleg,
  input  logic [XLEN-1:0]    fault_addr,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [31:0]        xform_insn,
  input  logic               is_rv32,
  input  logic [XLEN-1:0]    svec,
  input  logic [XLEN-1:0]    mvec,
  input  logic               rec_valid,
  input  logic [1:0]         rec_kind,
  input  logic               rec_two_stage,
  input  logic               rec_store,
  output logic               s_we,
  output logic               m_we,
  output logic [XLEN-1:0]    epc,
  output logic [XLEN-1:0]    tval,
  output logic [XLEN-1:0]    tinst,
  output logic               gva,
  output logic [XLEN-1:0]    new_pc,
  output logic [1:0]         new_priv,
  output logic               flag_two_stage,
  output logic               flag_indirect,
  output logic               flag_load
);

  logic            f_two, f_ind, f_load;
  logic            cls_ldst, cls_fetch;
  logic [XLEN-1:0] nx_tval, nx_tinst, nx_pc;
  logic            nx_gva, nx_to_s;

  trap_fault_rec u_rec (
    .clk           (clk),
    .rst_n         (rst_n),
    .rec_valid     (rec_valid),
    .rec_kind      (rec_kind_e'(rec_kind)),
    .rec_two_stage (rec_two_stage),
    .rec_store     (rec_store),
    .trap_fire     (trap_valid),
    .two_stage_q   (f_two),
    .indirect_q    (f_ind),
    .load_q        (f_load)
  );

  trap_classify #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_cls (
    .async_ev   (trap_async),
    .cause      (trap_cause),
    .fault_addr (fault_addr),
    .two_stage  (f_two),
    .indirect   (f_ind),
    .is_rv32    (is_rv32),
    .xform_insn (xform_insn),
    .cls_ldst   (cls_ldst),
    .cls_fetch  (cls_fetch),
    .tval       (nx_tval),
    .tinst      (nx_tinst),
    .gva        (nx_gva)
  );

  trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
    .async_ev  (trap_async),
    .cause     (trap_cause),
    .ideleg    (ideleg),
    .edeleg    (edeleg),
    .svec      (svec),
    .mvec      (mvec),
    .to_s      (nx_to_s),
    .target_pc (nx_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_we     <= 1'b0;
      m_we     <= 1'b0;
      epc      <= '0;
      tval     <= '0;
      tinst    <= '0;
      gva      <= 1'b0;
      new_pc   <= '0;
      new_priv <= PRIV_M;
    end else begin
      s_we <= trap_valid & nx_to_s;
      m_we <= trap_valid & ~nx_to_s;
      if (trap_valid) begin
        epc      <= cur_pc;
        tval     <= nx_tval;
        tinst    <= nx_tinst;
        gva      <= nx_gva;
        new_pc   <= nx_pc;
        new_priv <= nx_to_s ? PRIV_S : PRIV_M;
      end
    end
  end

  assign flag_two_stage = f_two;
  assign flag_indirect  = f_ind;
  assign flag_load      = f_load;

  assert_single_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> ($countones({s_we, m_we}) == 1));

  assert_no_spurious_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> !s_we && !m_we);

  assert_priv_matches_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_we |-> new_priv == PRIV_S);

  assert_async_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && trap_async |=> tval == '0 && tinst == '0 && !gva);

  assert_sync_m_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && !trap_async && !nx_to_s |=> new_pc == {$past(mvec[XLEN-1:2]), 2'b00});

  assert_fetch_no_tinst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && cls_fetch |=> tinst == '0);

endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;

  localparam int XLEN = 64;
  localparam int CW   = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trap_valid = 1'b0, trap_async = 1'b0;
  logic [CW-1:0]   trap_cause = '0;
  logic [XLEN-1:0] ideleg = '0, edeleg = '0, fault_addr = '0, cur_pc = '0;
  logic [31:0]     xform_insn = '0;
  logic            is_rv32 = 1'b0;
  logic [XLEN-1:0] svec = '0, mvec = '0;
  logic            rec_valid = 1'b0;
  logic [1:0]      rec_kind = '0;
  logic            rec_two_stage = 1'b0, rec_store = 1'b0;
  logic            s_we, m_we, gva;
  logic [XLEN-1:0] epc, tval, tinst, new_pc;
  logic [1:0]      new_priv;
  logic            flag_two_stage, flag_indirect, flag_load;

  always #5 clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN), .CAUSE_W(CW)) u_dut (.*);

  typedef struct {
    logic            to_s;
    logic [XLEN-1:0] epc, tval, tinst, pc;
    logic            gva;
    logic [1:0]      priv;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  logic m_two = 0, m_ind = 0, m_load = 0;

  task automatic check(input string tag, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic exp_t model(input logic a, input int c, input logic [XLEN-1:0] addr,
                                 input logic [XLEN-1:0] pc, input logic [31:0] xf,
                                 input logic rv32, input logic two, input logic ind,
                                 input string tag);
    exp_t e;
    logic [XLEN-1:0] b;
    bit ldst, fetch;
    ldst  = !a && (c inside {4, 5, 6, 7, 13, 15, 21, 23});
    fetch = !a && (c inside {0, 1, 12, 20});
    e.to_s = a ? ideleg[c] : edeleg[c];
    b = e.to_s ? svec : mvec;
    e.pc = b - XLEN'(b[1:0]);
    if (a && b[1:0] == 2'b01) e.pc = e.pc + XLEN'(c * 4);
    e.epc  = pc;
    e.priv = e.to_s ? 2'd1 : 2'd3;
    e.tval = (ldst || fetch) ? addr : '0;
    e.gva  = (ldst || fetch) ? two : 1'b0;
    e.tinst = '0;
    if (ldst) e.tinst = ind ? (rv32 ? 64'h2000 : 64'h3000) : XLEN'(xf);
    e.tag = tag;
    return e;
  endfunction

  task automatic do_trap(input logic a, input int c, input logic [XLEN-1:0] addr,
                         input logic [XLEN-1:0] pc, input logic [31:0] xf,
                         input logic rv32, input string tag, input bit with_rec = 0,
                         input logic [1:0] rk = 0, input logic rts = 0, input logic rst = 0);
    exp_q.push_back(model(a, c, addr, pc, xf, rv32, m_two, m_ind, tag));
    trap_valid = 1; trap_async = a; trap_cause = CW'(c);
    fault_addr = addr; cur_pc = pc; xform_insn = xf; is_rv32 = rv32;
    rec_valid = with_rec; rec_kind = rk; rec_two_stage = rts; rec_store = rst;
    if (with_rec) begin
      m_two = rts; m_ind = (rk == 2'd1); m_load = (rk == 2'd1) | ~rst;
    end else begin
      m_two = 0; m_ind = 0;
    end
    @(negedge clk);
    trap_valid = 0; rec_valid = 0;
  endtask

  task automatic do_rec(input logic [1:0] rk, input logic rts, input logic rst);
    rec_valid = 1; rec_kind = rk; rec_two_stage = rts; rec_store = rst;
    m_two = rts; m_ind = (rk == 2'd1); m_load = (rk == 2'd1) | ~rst;
    @(negedge clk);
    rec_valid = 0;
  endtask

  task automatic chk_flags(input string tag);
    check(tag, XLEN'({flag_two_stage, flag_indirect, flag_load}),
               XLEN'({m_two, m_ind, m_load}));
  endtask

  // monitor: pops the scoreboard on every write pulse
  always @(negedge clk) begin
    if (rst_n && (s_we || m_we)) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9 unexpected write pulse got s=%b m=%b exp none", s_we, m_we);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (s_we !== e.to_s || m_we !== !e.to_s || epc !== e.epc || tval !== e.tval ||
            tinst !== e.tinst || gva !== e.gva || new_pc !== e.pc || new_priv !== e.priv) begin
          n_bad++;
          $display("FAIL %s got s=%b pc=%h tval=%h tinst=%h gva=%b epc=%h priv=%0d exp s=%b pc=%h tval=%h tinst=%h gva=%b epc=%h priv=%0d",
                   e.tag, s_we, new_pc, tval, tinst, gva, epc, new_priv,
                   e.to_s, e.pc, e.tval, e.tinst, e.gva, e.epc, e.priv);
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 we", XLEN'({s_we, m_we}), '0);
    check("R1 values", epc | tval | tinst | new_pc, '0);
    check("R1 priv", XLEN'(new_priv), 64'd3);
    chk_flags("R1 flags");

    mvec = 64'h8000_0001; svec = 64'h4000_0102;
    edeleg = 64'h0000_0000_0020_2000; // bits 13, 21
    ideleg = 64'h0000_0000_0000_0020; // bit 5

    // R12 translation record, store, two-stage
    do_rec(2'd0, 1, 1); chk_flags("R12 xlate record");
    // R3 R5 store access fault to M, transformed insn
    do_trap(0, 7, 64'h1234_5678_9abc, 64'h100, 32'h00a5_a023, 0, "R3 R5 store access");
    chk_flags("R13 cleared after trap");

    // R11 walk record then page fault delegated to S (R2 R4 R9)
    do_rec(2'd1, 1, 1); chk_flags("R11 walk record");
    do_trap(0, 13, 64'hdead_0000, 64'h204, 32'h1111_2222, 0, "R4 R2 walk rv64");
    // R4 rv32 pseudo
    do_rec(2'd1, 0, 0);
    do_trap(0, 5, 64'h44, 64'h208, 32'h0, 1, "R4 walk rv32");

    // R12 bus error / misaligned clear indirect
    do_rec(2'd1, 1, 0); do_rec(2'd2, 1, 0); chk_flags("R12 bus error");
    do_rec(2'd1, 1, 0); do_rec(2'd3, 0, 1); chk_flags("R12 misaligned");

    // R6 fetch fault with two-stage flag
    do_rec(2'd0, 1, 0);
    do_trap(0, 12, 64'hcafe_f00c, 64'h300, 32'hffff_ffff, 0, "R6 fetch page");
    do_rec(2'd0, 1, 0);
    do_trap(0, 20, 64'h7777, 64'h304, 32'h1, 0, "R6 fetch guest page");

    // R7 R10 async vectored to M and to S (ideleg), R2 edeleg ignored for async
    do_rec(2'd0, 1, 0);
    do_trap(1, 7, 64'hffff, 64'h400, 32'h5, 0, "R7 R10 async vectored M");
    do_trap(1, 5, 64'h1, 64'h404, 32'h5, 0, "R2 R10 async to S mode2");
    do_trap(1, 13, 64'h1, 64'h408, 32'h5, 0, "R2 async ignores edeleg");

    // R10 sync with vectored base lands on base; R2 ideleg ignored for sync
    do_trap(0, 5, 64'h2, 64'h40c, 32'h7, 0, "R10 R2 sync vectored base");
    // R8 other sync
    do_trap(0, 2, 64'h9999, 64'h500, 32'h7, 0, "R8 illegal");

    // R13 same-cycle record and trap; flags before were clear
    do_trap(0, 21, 64'habc, 64'h600, 32'h0000_3003, 0, "R13 trap uses old flags",
            1, 2'd1, 1, 1);
    chk_flags("R13 record kept");
    do_trap(0, 23, 64'habd, 64'h604, 32'h0, 1, "R13 R4 next trap sees record");

    // R9 back-to-back traps
    exp_q.push_back(model(0, 4, 64'h10, 64'h700, 32'h1, 0, 0, 0, "R9 back2back a"));
    trap_valid = 1; trap_async = 0; trap_cause = 4; fault_addr = 64'h10; cur_pc = 64'h700;
    xform_insn = 32'h1; is_rv32 = 0;
    @(negedge clk);
    exp_q.push_back(model(1, 3, 64'h11, 64'h704, 32'h2, 0, 0, 0, "R9 back2back b"));
    trap_async = 1; trap_cause = 3; fault_addr = 64'h11; cur_pc = 64'h704; xform_insn = 32'h2;
    @(negedge clk);
    trap_valid = 0;
    repeat (3) @(negedge clk);
    check("R9 all pulses seen", XLEN'(exp_q.size()), '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule